// File: doc/BRIEF.md
# Speculative Line Read/Write Tracker

This block sits beside a private cache that runs code as atomic transactions. For each cache line it keeps a valid bit, a tag, a speculative-read flag and a speculative-write flag. Loads and stores from the local core set those flags while a transaction is open. The block also watches the addresses that other nodes broadcast when they commit. If a broadcast address hits a line that the local transaction has already read, the local work rests on stale data. The block then aborts the transaction. In that same edge it drops every line the transaction wrote and reports those lines on a one-cycle invalidate vector.

The block does not use ownership or sharing states. Several nodes may hold the same line at once, either clean or written speculatively. A commit broadcast either carries data, in which case the local copy is kept as an update, or carries only addresses, in which case a clean local copy is dropped.

Lines that hold speculative state must stay resident until the transaction ends. An eviction request against such a line is refused, and a stall flag is raised until the transaction commits or aborts. The stall also covers written lines when the write buffer keeps only addresses, which is set by a parameter.

The access, snoop and eviction ports index one line directly and carry the tag to compare or to install. Replacement policy lives outside this block.

Top module: `spec_line_tracker`

## Requirements
- R1: A load while a transaction is open installs the line (valid=1, tag from the port) and sets its bit in `spec_rd` on the next edge. A load with no open transaction installs the line and leaves `spec_rd` at zero. `spec_rd` and `spec_mod` are both all zero whenever `tx_active` is 0.
- R2: A store while a transaction is open installs the line and sets its bit in `spec_mod` on the next edge.
- R3: A snoop causes a violation when a transaction is open and the snooped line is valid, its tag equals `snp_tag`, and its read bit is set. The violation shows as `violation`=1 one cycle after the snoop, for exactly one cycle. A snoop whose tag differs causes no violation.
- R4: In the cycle `violation` is high, `flash_inv` equals the `spec_mod` vector held just before the abort. Every line in that vector is invalid, `spec_rd`, `spec_mod` and `tx_active` are all 0, and `flash_inv` returns to 0 in the next cycle.
- R5: `tx_commit` clears all of `spec_rd` and all of `spec_mod` and drops `tx_active` at one edge. `line_valid` is left unchanged.
- R6: An eviction request during a transaction against a valid line with its read bit set is refused. The line stays valid, and `overflow_stall` becomes 1 on the next edge. The flag holds until a commit or a violation.
- R7: With `ADDR_ONLY_WB`=1 (the default), an eviction of a line with its write bit set is also refused with `overflow_stall`. An eviction of a valid line with neither bit set clears its `line_valid` bit and raises no stall.
- R8: A matching snoop with `snp_has_data`=0 clears `line_valid` of a line whose write bit is clear. A matching snoop with `snp_has_data`=1 leaves the line valid.
- R9: A matching snoop against a line whose write bit is set and whose read bit is clear causes no violation. The line stays valid with its write bit set, in either snoop mode.
- R10: `tx_start` sets `tx_active` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Open a transaction |
| tx_commit | input | 1 | Local transaction committed |
| ld_valid | input | 1 | Local load this cycle |
| ld_idx | input | IDX_W | Line index of load |
| ld_tag | input | TAG_W | Tag of load |
| st_valid | input | 1 | Local store this cycle |
| st_idx | input | IDX_W | Line index of store |
| st_tag | input | TAG_W | Tag of store |
| snp_valid | input | 1 | Snooped commit address this cycle |
| snp_idx | input | IDX_W | Line index of snooped address |
| snp_tag | input | TAG_W | Tag of snooped address |
| snp_has_data | input | 1 | 1: packet carries data (update), 0: addresses only (invalidate) |
| evict_req | input | 1 | Request to evict a line |
| evict_idx | input | IDX_W | Line to evict |
| violation | output | 1 | One-cycle abort pulse |
| flash_inv | output | NUM_LINES | Lines dropped by the abort, one-cycle pulse |
| overflow_stall | output | 1 | Eviction of a protected line was refused |
| tx_active | output | 1 | Transaction open |
| line_valid | output | NUM_LINES | Per-line valid bits |
| spec_rd | output | NUM_LINES | Per-line speculative-read bits |
| spec_mod | output | NUM_LINES | Per-line speculative-write bits |

## Verification
The bench sweeps every line through each combination of read and write flags. It snoops each combination with a wrong tag and then with the right tag, alternating invalidate and update mode. A tracker that violated on write-only lines, or on wrong tags, would pulse `violation` where none is expected. A tracker that missed the gang drop would leave written lines valid, or keep `flash_inv` high for a second cycle. The same sweep is run with eviction requests: a missing stall would clear a protected line's valid bit, and a stall on a clean line would leave that line resident.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef struct packed {
    logic valid;
    logic rd;
    logic mod;
  } line_flags_t;
endpackage

// File: rtl/spt_tx_ctrl.sv
module spt_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_start,
  input  logic tx_commit,
  input  logic abort_now,
  input  logic ovf_now,
  output logic in_tx,
  output logic overflow_stall,
  output logic violation
);
  logic in_tx_n, ovf_n, viol_n;

  always_comb begin
    in_tx_n = in_tx;
    ovf_n   = overflow_stall;
    viol_n  = abort_now;
    if (abort_now || tx_commit) begin
      in_tx_n = 1'b0;
      ovf_n   = 1'b0;
    end else begin
      if (tx_start) in_tx_n = 1'b1;
      if (ovf_now)  ovf_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_tx          <= 1'b0;
      overflow_stall <= 1'b0;
      violation      <= 1'b0;
    end else begin
      in_tx          <= in_tx_n;
      overflow_stall <= ovf_n;
      violation      <= viol_n;
    end
  end

  AST_STALL_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_stall |-> in_tx); // R6
  AST_VIOL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> !violation); // R3
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !tx_commit && !abort_now) |=> in_tx); // R10
endmodule

// File: rtl/spt_line_cell.sv
module spt_line_cell #(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_tx,
  input  logic              ld_hit,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              st_hit,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic              snp_kill,
  input  logic              evict_go,
  input  logic              commit,
  input  logic              abort,
  output spt_pkg::line_flags_t flags,
  output logic [TAG_W-1:0]  tag
);
  spt_pkg::line_flags_t f_n;
  logic [TAG_W-1:0]     t_n;
  logic                 en;

  assign en = ld_hit | st_hit | snp_kill | evict_go | commit | abort;

  always_comb begin
    f_n = flags;
    t_n = tag;
    if (evict_go) f_n = '0;
    if (snp_kill) f_n.valid = 1'b0;
    if (ld_hit) begin
      if (!flags.valid || tag != ld_tag) begin
        f_n.rd  = 1'b0;
        f_n.mod = 1'b0;
      end
      f_n.valid = 1'b1;
      t_n = ld_tag;
      if (in_tx) f_n.rd = 1'b1;
    end
    if (st_hit) begin
      if (!flags.valid || tag != st_tag) begin
        f_n.rd  = 1'b0;
        f_n.mod = 1'b0;
      end
      f_n.valid = 1'b1;
      t_n = st_tag;
      if (in_tx) f_n.mod = 1'b1;
    end
    if (commit) begin
      f_n.rd  = 1'b0;
      f_n.mod = 1'b0;
    end
    if (abort) begin
      if (flags.mod) f_n.valid = 1'b0;
      f_n.rd  = 1'b0;
      f_n.mod = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      tag   <= '0;
    end else if (en) begin
      flags <= f_n;
      tag   <= t_n;
    end
  end

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!flags.rd && !flags.mod)); // R5
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && flags.mod) |=> !flags.valid); // R4
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker #(
  parameter int NUM_LINES    = 8,
  parameter int TAG_W        = 4,
  parameter bit ADDR_ONLY_WB = 1'b1,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_start,
  input  logic                 tx_commit,
  input  logic                 ld_valid,
  input  logic [IDX_W-1:0]     ld_idx,
  input  logic [TAG_W-1:0]     ld_tag,
  input  logic                 st_valid,
  input  logic [IDX_W-1:0]     st_idx,
  input  logic [TAG_W-1:0]     st_tag,
  input  logic                 snp_valid,
  input  logic [IDX_W-1:0]     snp_idx,
  input  logic [TAG_W-1:0]     snp_tag,
  input  logic                 snp_has_data,
  input  logic                 evict_req,
  input  logic [IDX_W-1:0]     evict_idx,
  output logic                 violation,
  output logic [NUM_LINES-1:0] flash_inv,
  output logic                 overflow_stall,
  output logic                 tx_active,
  output logic [NUM_LINES-1:0] line_valid,
  output logic [NUM_LINES-1:0] spec_rd,
  output logic [NUM_LINES-1:0] spec_mod
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  logic [TAG_W-1:0]     tag_arr [NUM_LINES];
  logic [NUM_LINES-1:0] snp_kill, evict_go, ld_hit, st_hit;
  logic                 snp_match, abort_now, ovf_now;
  logic [NUM_LINES-1:0] flash_n;

  assign snp_match = snp_valid && line_valid[snp_idx] && (tag_arr[snp_idx] == snp_tag);
  assign abort_now = tx_active && snp_match && spec_rd[snp_idx];
  assign ovf_now   = tx_active && evict_req && line_valid[evict_idx] &&
                     (spec_rd[evict_idx] || (ADDR_ONLY_WB && spec_mod[evict_idx]));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
      spt_pkg::line_flags_t fl;
      assign ld_hit[gi]   = ld_valid && (ld_idx == IDX_W'(gi));
      assign st_hit[gi]   = st_valid && (st_idx == IDX_W'(gi));
      assign snp_kill[gi] = snp_match && !snp_has_data && (snp_idx == IDX_W'(gi)) && !spec_mod[gi];
      assign evict_go[gi] = evict_req && !ovf_now && (evict_idx == IDX_W'(gi));

      spt_line_cell #(.TAG_W(TAG_W)) u_cell (
        .clk      (clk),
        .rst_n    (rst_sync),
        .in_tx    (tx_active),
        .ld_hit   (ld_hit[gi]),
        .ld_tag   (ld_tag),
        .st_hit   (st_hit[gi]),
        .st_tag   (st_tag),
        .snp_kill (snp_kill[gi]),
        .evict_go (evict_go[gi]),
        .commit   (tx_commit),
        .abort    (abort_now),
        .flags    (fl),
        .tag      (tag_arr[gi])
      );
      assign line_valid[gi] = fl.valid;
      assign spec_rd[gi]    = fl.rd;
      assign spec_mod[gi]   = fl.mod;
    end
  endgenerate

  spt_tx_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync),
    .tx_start       (tx_start),
    .tx_commit      (tx_commit),
    .abort_now      (abort_now),
    .ovf_now        (ovf_now),
    .in_tx          (tx_active),
    .overflow_stall (overflow_stall),
    .violation      (violation)
  );

  always_comb flash_n = abort_now ? spec_mod : '0;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) flash_inv <= '0;
    else           flash_inv <= flash_n;
  end

  AST_NO_SPEC_IDLE: assert property (@(posedge clk) disable iff (!rst_sync)
    !tx_active |-> (spec_rd == '0 && spec_mod == '0)); // R1
  AST_FLASH_WITH_VIOL: assert property (@(posedge clk) disable iff (!rst_sync)
    (flash_inv != '0) |-> violation); // R4
  AST_FLASH_GONE: assert property (@(posedge clk) disable iff (!rst_sync)
    violation |-> ((flash_inv & line_valid) == '0)); // R4
  AST_VIOL_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_sync)
    violation |-> $past(tx_active)); // R3
  AST_REFUSED_STAYS: assert property (@(posedge clk) disable iff (!rst_sync)
    ovf_now |=> line_valid[$past(evict_idx)]); // R6
endmodule

// File: tb/tb_spec_line_tracker.sv
module tb_spec_line_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_start = 0, tx_commit = 0;
  logic ld_valid = 0, st_valid = 0, snp_valid = 0, snp_has_data = 0, evict_req = 0;
  logic [IW-1:0] ld_idx = 0, st_idx = 0, snp_idx = 0, evict_idx = 0;
  logic [TW-1:0] ld_tag = 0, st_tag = 0, snp_tag = 0;
  logic violation, overflow_stall, tx_active;
  logic [N-1:0] flash_inv, line_valid, spec_rd, spec_mod;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_line_tracker #(.NUM_LINES(N), .TAG_W(TW), .ADDR_ONLY_WB(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_commit(tx_commit),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_tag(ld_tag),
    .st_valid(st_valid), .st_idx(st_idx), .st_tag(st_tag),
    .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_tag(snp_tag), .snp_has_data(snp_has_data),
    .evict_req(evict_req), .evict_idx(evict_idx),
    .violation(violation), .flash_inv(flash_inv), .overflow_stall(overflow_stall),
    .tx_active(tx_active), .line_valid(line_valid), .spec_rd(spec_rd), .spec_mod(spec_mod));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  function automatic logic [TW-1:0] tg(input int j, input int i);
    return TW'((j * 3 + i) % 16);
  endfunction

  task automatic do_load(input int idx, input logic [TW-1:0] t);
    ld_valid = 1; ld_idx = IW'(idx); ld_tag = t; cyc(); ld_valid = 0;
  endtask

  task automatic do_store(input int idx, input logic [TW-1:0] t);
    st_valid = 1; st_idx = IW'(idx); st_tag = t; cyc(); st_valid = 0;
  endtask

  task automatic preload(input int i);
    for (int j = 0; j < N; j++) do_load(j, tg(j, i));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] e_rd, e_mod, e_val, bit_i, bit_k;
    bit has_rd, has_mod, dat, exp_v, stall;
    int k;
    #(CLK_PERIOD * 2 + 1);
    rst_n = 1;
    cyc(); cyc(); cyc();
    chk(line_valid == 0 && spec_rd == 0 && spec_mod == 0 && !tx_active && !violation
        && !overflow_stall && flash_inv == 0, "reset", {line_valid, spec_rd, spec_mod}, 0);

    // sweep 1: snoop against each line with each flag combination
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 4; c++) begin
        has_rd = c[0]; has_mod = c[1]; dat = i[0];
        k = (i + 1) % N;
        bit_i = N'(1) << i; bit_k = N'(1) << k;
        preload(i);
        chk(line_valid == {N{1'b1}} && spec_rd == 0, "R1 load outside tx", {line_valid, spec_rd}, {{N{1'b1}}, {N{1'b0}}});
        tx_start = 1; cyc(); tx_start = 0;
        chk(tx_active == 1, "R10", tx_active, 1);
        if (has_rd)  do_load(i, tg(i, i));
        if (has_mod) do_store(i, tg(i, i));
        do_store(k, tg(k, i));
        e_rd  = has_rd ? bit_i : '0;
        e_mod = bit_k | (has_mod ? bit_i : '0);
        chk(spec_rd == e_rd, "R1 read bit", spec_rd, e_rd);
        chk(spec_mod == e_mod, "R2 write bit", spec_mod, e_mod);
        // wrong tag: no effect
        snp_valid = 1; snp_idx = IW'(i); snp_tag = tg(i, i) ^ 4'h1; snp_has_data = 0;
        cyc(); snp_valid = 0;
        chk(!violation && line_valid == {N{1'b1}}, "R3 tag mismatch", {violation, line_valid}, {1'b0, {N{1'b1}}});
        // matching snoop
        snp_valid = 1; snp_idx = IW'(i); snp_tag = tg(i, i); snp_has_data = dat;
        cyc(); snp_valid = 0;
        if (has_rd) begin
          exp_v = !has_mod && dat;
          e_val = ~e_mod;
          if (!exp_v) e_val = e_val & ~bit_i;
          chk(violation == 1, "R3 violation", violation, 1);
          chk(flash_inv == e_mod, "R4 flash vector", flash_inv, e_mod);
          chk(line_valid == e_val, "R4 lines dropped", line_valid, e_val);
          chk(spec_rd == 0 && spec_mod == 0 && !tx_active, "R4 state cleared",
              {spec_rd, spec_mod, tx_active}, 0);
          cyc();
          chk(!violation && flash_inv == 0, "R4 pulse ends", {violation, flash_inv}, 0);
        end else begin
          exp_v = has_mod || dat;
          e_val = {N{1'b1}};
          if (!exp_v) e_val = e_val & ~bit_i;
          chk(violation == 0, has_mod ? "R9 no violation" : "R3 no read no violation", violation, 0);
          chk(line_valid == e_val, has_mod ? "R9 line kept" : "R8 snoop mode", line_valid, e_val);
          chk(spec_mod == e_mod, "R9 write bit kept", spec_mod, e_mod);
          tx_commit = 1; cyc(); tx_commit = 0;
          chk(spec_rd == 0 && spec_mod == 0 && !tx_active && line_valid == e_val, "R5 commit",
              {spec_rd, spec_mod, tx_active, line_valid}, {{N{1'b0}}, {N{1'b0}}, 1'b0, e_val});
        end
      end
    end

    // sweep 2: eviction against each line with each flag combination
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 4; c++) begin
        has_rd = c[0]; has_mod = c[1];
        bit_i = N'(1) << i;
        preload(i);
        tx_start = 1; cyc(); tx_start = 0;
        if (has_rd)  do_load(i, tg(i, i));
        if (has_mod) do_store(i, tg(i, i));
        evict_req = 1; evict_idx = IW'(i); cyc(); evict_req = 0;
        stall = has_rd || has_mod;
        e_val = stall ? {N{1'b1}} : ~bit_i;
        chk(overflow_stall == stall, has_rd ? "R6 stall" : "R7 stall", overflow_stall, stall);
        chk(line_valid == e_val, has_rd ? "R6 line kept" : "R7 eviction", line_valid, e_val);
        cyc();
        chk(overflow_stall == stall, "R6 stall held", overflow_stall, stall);
        tx_commit = 1; cyc(); tx_commit = 0;
        chk(!overflow_stall && !tx_active, "R6 stall released", {overflow_stall, tx_active}, 0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule